// File: doc/BRIEF.md
# Serial Receive Front End

This block sits right after the bit sampler of a serial receiver. On each bit strobe it takes one sampled bit. The bit comes from the receive pin, or from the local transmit line when loopback is on, and can be complemented. While idle the block searches that stream for a 16-bit start-of-frame delimiter. The search always runs in the order the bits arrive on the wire.

Once the delimiter is found, the block packs the following bits into bytes. The chosen bit order applies only to this packing step. It then counts a programmable number of header bytes. From that count it produces three enables for downstream engines:
- CRC calculation.
- DC-bias removal.
- Bit destuffing. The destuffing window opens either at the delimiter or at the end of the header, as selected.

An external frame-end pulse sends the block back to delimiter search.

Top module: `srx_front`

## Requirements
- R1: With `cfg_invert_i` = 1, every sampled bit is complemented before delimiter search and byte packing.
- R2: With `cfg_loop_i` = 1, the bit is taken from `tx_bit_i` and `rx_bit_i` is ignored. With 0, the bit is taken from `rx_bit_i`.
- R3: The delimiter (default 16'hF3A0) is compared against the last 16 strobed bits. The earliest bit sits in the pattern MSB. This holds whatever the value of `cfg_msb_first_i`. A pattern differing in any bit starts no frame.
- R4: With `cfg_msb_first_i` = 1, the first bit after the delimiter becomes byte bit 7. With 0, it becomes byte bit 0.
- R5: `byte_valid_o` is high for exactly one cycle, in the cycle after the strobe of every eighth bit following the delimiter. `byte_o` holds the packed byte in that cycle.
- R6: `crc_en_o` rises in the cycle of the `cfg_hdr_len_i`-th byte pulse. If the length is 0, it rises in the cycle after the delimiter's last bit. It stays high until frame end.
- R7: With `cfg_stuff_late_i` = 0, `destuff_en_o` is high from the cycle after the delimiter's last bit. With 1, it follows `crc_en_o`.
- R8: `cfg_stuff_dis_i` = 1 holds `destuff_en_o` low.
- R9: `dcb_en_o` equals `crc_en_o` when `cfg_dcb_en_i` = 1, and is low otherwise.
- R10: After a cycle with `frame_end_i` = 1, all enables and `byte_valid_o` are low and delimiter search restarts. A partial byte is discarded.
- R11: After reset, all outputs are 0.
- R12: While no delimiter has been seen, no byte pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Strobe: one sampled bit this cycle |
| rx_bit_i | input | 1 | Sampled receive bit |
| tx_bit_i | input | 1 | Local transmit serial bit (loopback source) |
| cfg_invert_i | input | 1 | Complement incoming bits |
| cfg_loop_i | input | 1 | Select transmit line as source |
| cfg_msb_first_i | input | 1 | Byte packing order, 1 = MSB first |
| cfg_hdr_len_i | input | 4 | Header byte count before CRC/DC-bias enable |
| cfg_stuff_late_i | input | 1 | Destuff window opens after header |
| cfg_stuff_dis_i | input | 1 | Force destuff window closed |
| cfg_dcb_en_i | input | 1 | Allow DC-bias removal enable |
| frame_end_i | input | 1 | End frame, return to search |
| byte_valid_o | output | 1 | Byte ready pulse |
| byte_o | output | 8 | Packed byte |
| crc_en_o | output | 1 | CRC calculation enable |
| dcb_en_o | output | 1 | DC-bias removal enable |
| destuff_en_o | output | 1 | Bit destuffing window |

## Verification
The hardest case to reach is the interaction of transformed input with wire-order search. With inversion or loopback on, the delimiter must be found on the transformed stream, but never in the packing order. The bench sweeps all eight combinations of invert, loopback and bit order against every header length from 0 to 15. It drives the complemented wire level, and in loopback it drives the opposite level on the unused pin. Near-miss delimiters and a frame end cut mid-byte probe the search restart and the discard of partial bytes.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_DATA = 1'b1} rx_state_e;
endpackage

// File: rtl/srx_bit_select.sv
module srx_bit_select (
  input  logic rx_bit_i,
  input  logic tx_bit_i,
  input  logic loop_i,
  input  logic invert_i,
  output logic bit_o
);
  always_comb bit_o = (loop_i ? tx_bit_i : rx_bit_i) ^ invert_i;
endmodule

// File: rtl/srx_sfd_hunt.sv
module srx_sfd_hunt #(
  parameter int unsigned SFD_W = 16,
  parameter logic [SFD_W-1:0] SFD = 16'hF3A0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic hunt_i,
  input  logic clear_i,
  output logic match_o
);
  logic [SFD_W-1:0] sr_q, sr_next;

  always_comb sr_next = {sr_q[SFD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (bit_valid_i && hunt_i) sr_q <= sr_next;
  end

  // raw wire order: earliest bit lands in MSB
  always_comb match_o = hunt_i && bit_valid_i && !clear_i && (sr_next == SFD);
endmodule

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              active_i,
  input  logic              msb_first_i,
  input  logic              clear_i,
  output logic              byte_strobe_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shf_q, shf_next;
  logic              last, take;

  always_comb begin
    shf_next = msb_first_i ? {shf_q[BYTE_W-2:0], bit_i} : {bit_i, shf_q[BYTE_W-1:1]};
    last     = (cnt_q == CNT_W'(BYTE_W - 1));
    take     = active_i && bit_valid_i && !clear_i;
    byte_strobe_o = take && last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      shf_q        <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (clear_i) begin
        cnt_q <= '0;
      end else if (take) begin
        shf_q <= shf_next;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        if (last) begin
          byte_valid_o <= 1'b1;
          byte_o       <= shf_next;
        end
      end
    end
  end
endmodule

// File: rtl/srx_hdr_gate.sv
module srx_hdr_gate #(
  parameter int unsigned HDR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             active_i,
  input  logic             byte_strobe_i,
  input  logic [HDR_W-1:0] hdr_len_i,
  input  logic             stuff_late_i,
  input  logic             stuff_dis_i,
  input  logic             dcb_cfg_i,
  output logic             crc_en_o,
  output logic             dcb_en_o,
  output logic             destuff_en_o
);
  logic [HDR_W-1:0] hdr_q;
  logic             done;

  always_comb done = (hdr_q >= hdr_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hdr_q <= '0;
    else if (clear_i) hdr_q <= '0;
    else if (byte_strobe_i && !done) hdr_q <= hdr_q + 1'b1;
  end

  always_comb begin
    crc_en_o     = active_i && done;
    dcb_en_o     = crc_en_o && dcb_cfg_i;
    destuff_en_o = active_i && !stuff_dis_i && (!stuff_late_i || done);
  end
endmodule

// File: rtl/srx_front.sv
module srx_front #(
  parameter int unsigned SFD_W  = 16,
  parameter logic [SFD_W-1:0] SFD = 16'hF3A0,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HDR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              rx_bit_i,
  input  logic              tx_bit_i,
  input  logic              cfg_invert_i,
  input  logic              cfg_loop_i,
  input  logic              cfg_msb_first_i,
  input  logic [HDR_W-1:0]  cfg_hdr_len_i,
  input  logic              cfg_stuff_late_i,
  input  logic              cfg_stuff_dis_i,
  input  logic              cfg_dcb_en_i,
  input  logic              frame_end_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              crc_en_o,
  output logic              dcb_en_o,
  output logic              destuff_en_o
);
  import srx_pkg::*;

  rx_state_e state_q;
  logic      bit_s, match, active, restart, byte_strobe;

  always_comb begin
    active  = (state_q == ST_DATA);
    restart = frame_end_i || match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT;
    else if (frame_end_i) state_q <= ST_HUNT;
    else if (match) state_q <= ST_DATA;
  end

  srx_bit_select u_sel (
    .rx_bit_i (rx_bit_i),
    .tx_bit_i (tx_bit_i),
    .loop_i   (cfg_loop_i),
    .invert_i (cfg_invert_i),
    .bit_o    (bit_s)
  );

  srx_sfd_hunt #(.SFD_W(SFD_W), .SFD(SFD)) u_hunt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_s),
    .hunt_i      (!active),
    .clear_i     (frame_end_i),
    .match_o     (match)
  );

  srx_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bit_valid_i   (bit_valid_i),
    .bit_i         (bit_s),
    .active_i      (active),
    .msb_first_i   (cfg_msb_first_i),
    .clear_i       (restart),
    .byte_strobe_o (byte_strobe),
    .byte_valid_o  (byte_valid_o),
    .byte_o        (byte_o)
  );

  srx_hdr_gate #(.HDR_W(HDR_W)) u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (restart),
    .active_i      (active),
    .byte_strobe_i (byte_strobe),
    .hdr_len_i     (cfg_hdr_len_i),
    .stuff_late_i  (cfg_stuff_late_i),
    .stuff_dis_i   (cfg_stuff_dis_i),
    .dcb_cfg_i     (cfg_dcb_en_i),
    .crc_en_o      (crc_en_o),
    .dcb_en_o      (dcb_en_o),
    .destuff_en_o  (destuff_en_o)
  );
endmodule

// File: rtl/srx_front_chk.sv
module srx_front_chk #(
  parameter int unsigned HDR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_valid_i,
  input logic             frame_end_i,
  input logic             cfg_dcb_en_i,
  input logic             cfg_stuff_dis_i,
  input logic [HDR_W-1:0] cfg_hdr_len_i,
  input logic             byte_valid_o,
  input logic             crc_en_o,
  input logic             dcb_en_o,
  input logic             destuff_en_o
);
  p_byte_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  p_byte_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(bit_valid_i));

  p_crc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_en_o && !frame_end_i) |=> (crc_en_o || (cfg_hdr_len_i != $past(cfg_hdr_len_i))));

  p_stuff_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_stuff_dis_i |-> !destuff_en_o);

  p_dcb_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcb_en_o |-> (crc_en_o && cfg_dcb_en_i));

  p_end_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (!crc_en_o && !destuff_en_o && !byte_valid_o));
endmodule

bind srx_front srx_front_chk #(.HDR_W(HDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bit_valid_i     (bit_valid_i),
  .frame_end_i     (frame_end_i),
  .cfg_dcb_en_i    (cfg_dcb_en_i),
  .cfg_stuff_dis_i (cfg_stuff_dis_i),
  .cfg_hdr_len_i   (cfg_hdr_len_i),
  .byte_valid_o    (byte_valid_o),
  .crc_en_o        (crc_en_o),
  .dcb_en_o        (dcb_en_o),
  .destuff_en_o    (destuff_en_o)
);

// File: tb/srx_front_test.sv
`timescale 1ns/1ps
module srx_front_test;
  localparam logic [15:0] SFD = 16'hF3A0;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_valid_i = 1'b0, rx_bit_i = 1'b0, tx_bit_i = 1'b0;
  logic       cfg_invert_i = 1'b0, cfg_loop_i = 1'b0, cfg_msb_first_i = 1'b0;
  logic [3:0] cfg_hdr_len_i = 4'd0;
  logic       cfg_stuff_late_i = 1'b0, cfg_stuff_dis_i = 1'b0, cfg_dcb_en_i = 1'b0;
  logic       frame_end_i = 1'b0;
  logic       byte_valid_o, crc_en_o, dcb_en_o, destuff_en_o;
  logic [7:0] byte_o;

  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  srx_front uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_valid_i(bit_valid_i), .rx_bit_i(rx_bit_i),
    .tx_bit_i(tx_bit_i), .cfg_invert_i(cfg_invert_i), .cfg_loop_i(cfg_loop_i),
    .cfg_msb_first_i(cfg_msb_first_i), .cfg_hdr_len_i(cfg_hdr_len_i),
    .cfg_stuff_late_i(cfg_stuff_late_i), .cfg_stuff_dis_i(cfg_stuff_dis_i),
    .cfg_dcb_en_i(cfg_dcb_en_i), .frame_end_i(frame_end_i),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .crc_en_o(crc_en_o),
    .dcb_en_o(dcb_en_o), .destuff_en_o(destuff_en_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // logical bit lb; wire carries lb^invert; unused pin gets the opposite level
  task automatic tick_bit(input logic lb);
    logic w;
    w = lb ^ cfg_invert_i;
    @(negedge clk);
    if (cfg_loop_i) begin tx_bit_i = w; rx_bit_i = ~w; end
    else begin rx_bit_i = w; tx_bit_i = ~w; end
    bit_valid_i = 1'b1;
    @(negedge clk);
    bit_valid_i = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk);
    frame_end_i = 1'b1;
    @(negedge clk);
    frame_end_i = 1'b0;
    chk("R10 crc_en after end", crc_en_o, 0);
    chk("R10 destuff after end", destuff_en_o, 0);
    chk("R10 dcb after end", dcb_en_o, 0);
  endtask

  task automatic check_enables(input int hl, input int nb, input string tag);
    int crc_x, ds_x;
    crc_x = (nb >= hl) ? 1 : 0;
    ds_x  = cfg_stuff_dis_i ? 0 : (cfg_stuff_late_i ? crc_x : 1);
    chk({tag, " R6 crc_en"}, crc_en_o, crc_x);
    chk({tag, cfg_stuff_dis_i ? " R8 destuff" : " R7 destuff"}, destuff_en_o, ds_x);
    chk({tag, " R9 dcb_en"}, dcb_en_o, crc_x & int'(cfg_dcb_en_i));
  endtask

  task automatic send_frame(input int mode, input int hl, input int nbytes);
    logic [7:0] d;
    string tag;
    cfg_invert_i     = mode[0];
    cfg_loop_i       = mode[1];
    cfg_msb_first_i  = mode[2];
    cfg_hdr_len_i    = 4'(hl);
    cfg_stuff_late_i = hl[0] ^ mode[0];
    cfg_stuff_dis_i  = ((hl + mode) % 5) == 0;
    cfg_dcb_en_i     = hl[1] ^ mode[1];
    tag = cfg_invert_i ? "R1" : (cfg_loop_i ? "R2" : "R3");
    for (int i = 0; i < 20; i++) tick_bit(1'(i & 1));
    chk("R12 no byte while hunting", byte_valid_o, 0);
    chk("R12 crc_en low while hunting", crc_en_o, 0);
    for (int i = 15; i >= 0; i--) tick_bit(SFD[i]);
    check_enables(hl, 0, {tag, " after delimiter"});
    for (int k = 1; k <= nbytes; k++) begin
      d = 8'(k * 37 + hl * 11 + mode * 3 + 8'h5A);
      for (int i = 0; i < 8; i++) begin
        tick_bit(cfg_msb_first_i ? d[7 - i] : d[i]);
        if (i != 7) chk("R5 no pulse mid-byte", byte_valid_o, 0);
      end
      chk({tag, " R5 byte_valid"}, byte_valid_o, 1);
      chk({tag, " R4 byte data"}, byte_o, d);
      check_enables(hl, k, tag);
      @(negedge clk);
      chk("R5 single pulse", byte_valid_o, 0);
    end
    end_frame();
  endtask

  initial begin
    #750000;
    n_vec++; n_bad++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 byte_valid in reset", byte_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 byte_valid", byte_valid_o, 0);
    chk("R11 byte_o", byte_o, 0);
    chk("R11 crc_en", crc_en_o, 0);
    chk("R11 dcb_en", dcb_en_o, 0);
    chk("R11 destuff_en", destuff_en_o, 0);

    // near-miss delimiter: last bit flipped, then a byte of data
    for (int i = 15; i >= 0; i--) tick_bit(SFD[i] ^ (i == 0));
    for (int i = 0; i < 8; i++) tick_bit(1'b0);
    chk("R3 near-miss: no byte", byte_valid_o, 0);
    chk("R3 near-miss: no window", destuff_en_o, 0);
    end_frame();

    // frame end mid-byte, then a clean frame must realign
    for (int i = 15; i >= 0; i--) tick_bit(SFD[i]);
    chk("R7 early window open", destuff_en_o, 1);
    for (int i = 0; i < 3; i++) tick_bit(1'b1);
    end_frame();
    for (int i = 0; i < 5; i++) tick_bit(1'b0);
    chk("R10 partial byte dropped", byte_valid_o, 0);
    send_frame(0, 0, 2);

    for (int hl = 0; hl < 16; hl++)
      for (int mode = 0; mode < 8; mode++)
        send_frame(mode, hl, hl + 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule